// File: doc/BRIEF.md
# Video Beam Position Counter

This block keeps the raster beam position of a video chip. A horizontal counter steps once for every colour-clock enable. A vertical counter steps once at the end of every line. Two raster geometries are available. In the 50 Hz geometry every line has the same length. In the 60 Hz geometry a short line and a long line take turns.

For interlaced output the block keeps a long-field flag. This flag decides whether the current field has its full line count or one line fewer. The counters therefore stop at different terminal values from one line to the next and from one field to the next.

The block emits single-cycle strobes for the start of a line and the start of a frame. It also packs the position into two 16-bit status words for read-back.

Top module: `beam_counter`

## Requirements
- R1: `hpos` increases by one on every clock where `cck_en` is high and the line is not at its last position. When `cck_en` is low, `hpos`, `vpos`, the flags and the status words hold their values and no strobe is raised.
- R2: With `mode_60` = 0, a line runs `hpos` 0..226 (227 colour clocks) and `long_line` is 0 after every line start. A field with interlace off has 313 lines (`vpos` 0..312).
- R3: With `mode_60` = 1, `long_line` toggles at every line start. A line with `long_line` = 1 is 228 colour clocks (`hpos` 0..227), and a line with `long_line` = 0 is 227. A full field has 263 lines.
- R4: With `lace_en` = 1, `long_field` toggles when `vpos` wraps to 0. A field that begins with `long_field` = 1 has the full line count (313 or 263). A field that begins with `long_field` = 0 has one line fewer (312 or 262).
- R5: With `lace_en` = 0, `long_field` is set to 1 when `vpos` wraps, and the field uses the full line count.
- R6: `line_start` is high for exactly one clock, in the clock after the edge that wraps `hpos` to 0. `frame_start` is high in that same clock only when `vpos` also wrapped to 0.
- R7: `pos_lo` holds `vpos[7:0]` in bits 15:8 and `hpos[8:1]` (half colour-clock resolution) in bits 7:0.
- R8: `pos_hi` holds `long_field` in bit 15 and `vpos[8]` in bit 0. Bits 14:1 are zero.
- R9: While `rst_n` is low: `hpos` = 0, `vpos` = 0, `long_line` = 0, `long_field` = 1, and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cck_en | input | 1 | Colour-clock enable, one beam step per high cycle |
| mode_60 | input | 1 | 1 selects the 60 Hz geometry, 0 selects the 50 Hz geometry |
| lace_en | input | 1 | Interlace enable |
| hpos | output | 9 | Horizontal position in colour clocks |
| vpos | output | 9 | Vertical line number |
| line_start | output | 1 | One-clock strobe when `hpos` wraps to 0 |
| frame_start | output | 1 | One-clock strobe when `vpos` wraps to 0 |
| long_line | output | 1 | The current line is a long line (60 Hz geometry) |
| long_field | output | 1 | The current field is a long field |
| pos_hi | output | 16 | Status word: `long_field` and the high bit of `vpos` |
| pos_lo | output | 16 | Status word: low byte of `vpos` and `hpos` halved |

## Verification
The bench runs a behavioural model of the beam alongside the design and compares the two on every clock. The run covers three fields in sequence, each field length of interest in turn:
- A full 50 Hz field with interlace off. A design that ignored the disabled interlace would toggle `long_field` here.
- A long 60 Hz interlaced field.
- A short 60 Hz interlaced field. A design that dropped the line on the wrong field, or on both fields, would show the wrong `vpos` terminal value.

The enable has gaps early in the run, so a counter that advanced without `cck_en` would drift away from the model. An off-by-one between the long and short 60 Hz lines would shift `hpos` one place early at every other line start. An independent count of `line_start` pulses per field catches a wrong field length even if both strobes stay aligned.

// File: rtl/beam_pkg.sv
package beam_pkg;
    localparam int HPOS_W = 9;
    localparam int VPOS_W = 9;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic [HPOS_W-1:0] hpos;
        logic              long_line;
        logic              line_start;
    } hstate_t;

    typedef struct packed {
        logic [VPOS_W-1:0] vpos;
        logic              long_field;
        logic              frame_start;
    } vstate_t;

    localparam hstate_t HSTATE_RST = '{hpos: '0, long_line: 1'b0, line_start: 1'b0};
    localparam vstate_t VSTATE_RST = '{vpos: '0, long_field: 1'b1, frame_start: 1'b0};
endpackage

// File: rtl/beam_hcount.sv
module beam_hcount
    import beam_pkg::*;
#(
    parameter int SHORT_LEN = 227
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cck_en,
    input  logic              mode_60,
    output logic [HPOS_W-1:0] hpos,
    output logic              long_line,
    output logic              line_start,
    output logic              line_end
);
    localparam logic [HPOS_W-1:0] LAST_SHORT = HPOS_W'(SHORT_LEN - 1);

    hstate_t           h_d, h_q;
    logic [HPOS_W-1:0] last_pos;

    always_comb begin
        last_pos = LAST_SHORT + HPOS_W'(mode_60 && h_q.long_line);
        line_end = cck_en && (h_q.hpos >= last_pos);
        h_d = h_q;
        h_d.line_start = 1'b0;
        if (cck_en) begin
            if (line_end) begin
                h_d.hpos       = '0;
                h_d.line_start = 1'b1;
                h_d.long_line  = mode_60 && !h_q.long_line;
            end else begin
                h_d.hpos = h_q.hpos + HPOS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= HSTATE_RST;
        else        h_q <= h_d;
    end

    assign hpos       = h_q.hpos;
    assign long_line  = h_q.long_line;
    assign line_start = h_q.line_start;
endmodule

// File: rtl/beam_vcount.sv
module beam_vcount
    import beam_pkg::*;
#(
    parameter int LINES_50 = 313,
    parameter int LINES_60 = 263
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              mode_60,
    input  logic              lace_en,
    output logic [VPOS_W-1:0] vpos,
    output logic              long_field,
    output logic              frame_start
);
    localparam logic [VPOS_W-1:0] LAST_50 = VPOS_W'(LINES_50 - 1);
    localparam logic [VPOS_W-1:0] LAST_60 = VPOS_W'(LINES_60 - 1);

    vstate_t           v_d, v_q;
    logic [VPOS_W-1:0] last_line;

    always_comb begin
        last_line = (mode_60 ? LAST_60 : LAST_50)
                  - VPOS_W'(lace_en && !v_q.long_field);
        v_d = v_q;
        v_d.frame_start = 1'b0;
        if (line_end) begin
            if (v_q.vpos >= last_line) begin
                v_d.vpos        = '0;
                v_d.frame_start = 1'b1;
                v_d.long_field  = lace_en ? !v_q.long_field : 1'b1;
            end else begin
                v_d.vpos = v_q.vpos + VPOS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= VSTATE_RST;
        else        v_q <= v_d;
    end

    assign vpos        = v_q.vpos;
    assign long_field  = v_q.long_field;
    assign frame_start = v_q.frame_start;
endmodule

// File: rtl/beam_status.sv
module beam_status
    import beam_pkg::*;
(
    input  logic [VPOS_W-1:0] vpos,
    input  logic [HPOS_W-1:1] hpos_half,
    input  logic              long_field,
    output logic [WORD_W-1:0] pos_hi,
    output logic [WORD_W-1:0] pos_lo
);
    localparam int HI_PAD = WORD_W - 1 - (VPOS_W - 8);

    always_comb begin
        pos_lo = {vpos[7:0], hpos_half};
        pos_hi = {long_field, {HI_PAD{1'b0}}, vpos[VPOS_W-1:8]};
    end
endmodule

// File: rtl/beam_counter.sv
module beam_counter
    import beam_pkg::*;
#(
    parameter int SHORT_LEN = 227,
    parameter int LINES_50  = 313,
    parameter int LINES_60  = 263
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cck_en,
    input  logic              mode_60,
    input  logic              lace_en,
    output logic [HPOS_W-1:0] hpos,
    output logic [VPOS_W-1:0] vpos,
    output logic              line_start,
    output logic              frame_start,
    output logic              long_line,
    output logic              long_field,
    output logic [WORD_W-1:0] pos_hi,
    output logic [WORD_W-1:0] pos_lo
);
    logic line_end;

    beam_hcount #(.SHORT_LEN(SHORT_LEN)) u_h (
        .clk(clk), .rst_n(rst_n), .cck_en(cck_en), .mode_60(mode_60),
        .hpos(hpos), .long_line(long_line), .line_start(line_start),
        .line_end(line_end)
    );

    beam_vcount #(.LINES_50(LINES_50), .LINES_60(LINES_60)) u_v (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .mode_60(mode_60),
        .lace_en(lace_en), .vpos(vpos), .long_field(long_field),
        .frame_start(frame_start)
    );

    beam_status u_s (
        .vpos(vpos), .hpos_half(hpos[HPOS_W-1:1]), .long_field(long_field),
        .pos_hi(pos_hi), .pos_lo(pos_lo)
    );
endmodule

// File: rtl/beam_counter_chk.sv
module beam_counter_chk
    import beam_pkg::*;
#(
    parameter int SHORT_LEN = 227,
    parameter int LINES_50  = 313
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cck_en,
    input logic              mode_60,
    input logic              lace_en,
    input logic [HPOS_W-1:0] hpos,
    input logic [VPOS_W-1:0] vpos,
    input logic              line_start,
    input logic              frame_start,
    input logic              long_line,
    input logic              long_field
);
    AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cck_en |=> (hpos == $past(hpos) + HPOS_W'(1)) || line_start); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cck_en |=> $stable(hpos) && $stable(vpos) && !line_start); // R1
    AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hpos <= HPOS_W'(SHORT_LEN)); // R3
    AST_VPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vpos < VPOS_W'(LINES_50)); // R2
    AST_LONG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && $past(mode_60)) |-> (long_line != $past(long_line))); // R3
    AST_NOLACE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !$past(lace_en)) |-> long_field); // R5
    AST_FIELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(long_field)); // R4
    AST_LINE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (hpos == '0) ##1 !line_start); // R6
    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start && (vpos == '0)); // R6
endmodule

bind beam_counter beam_counter_chk #(.SHORT_LEN(SHORT_LEN), .LINES_50(LINES_50)) u_chk (
    .clk(clk), .rst_n(rst_n), .cck_en(cck_en), .mode_60(mode_60),
    .lace_en(lace_en), .hpos(hpos), .vpos(vpos), .line_start(line_start),
    .frame_start(frame_start), .long_line(long_line), .long_field(long_field)
);

// File: tb/beam_counter_test.sv
module beam_counter_test;
    logic clk = 1'b0;
    logic rst_n, cck_en, mode_60, lace_en;
    logic [8:0]  hpos, vpos;
    logic        line_start, frame_start, long_line, long_field;
    logic [15:0] pos_hi, pos_lo;

    int vectors = 0, errors = 0, cycles = 0;
    int m_h = 0, m_v = 0, m_ll = 0, m_lf = 1, m_ls = 0, m_fs = 0;
    int phase = 0, line_cnt = 1, exp_lines = 313;
    bit done = 0;

    always #10 clk = ~clk;

    beam_counter uut (
        .clk(clk), .rst_n(rst_n), .cck_en(cck_en), .mode_60(mode_60),
        .lace_en(lace_en), .hpos(hpos), .vpos(vpos), .line_start(line_start),
        .frame_start(frame_start), .long_line(long_line), .long_field(long_field),
        .pos_hi(pos_hi), .pos_lo(pos_lo)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // Reference beam: advance one clock with the given inputs
    task automatic model_step(input bit en, input bit m60, input bit lace);
        int len, lines;
        m_ls = 0;
        m_fs = 0;
        if (!en) return;
        len = (m60 && m_ll == 1) ? 228 : 227;
        if (m_h + 1 < len) begin
            m_h++;
            return;
        end
        m_h = 0;
        m_ls = 1;
        m_ll = m60 ? 1 - m_ll : 0;
        lines = (m60 ? 263 : 313) - ((lace && m_lf == 0) ? 1 : 0);
        if (m_v + 1 < lines) begin
            m_v++;
        end else begin
            m_v = 0;
            m_fs = 1;
            m_lf = lace ? 1 - m_lf : 1;
        end
    endtask

    task automatic compare_all();
        chk("R1", "hpos", hpos, m_h);
        chk("R2/R3", "vpos", vpos, m_v);
        chk("R3", "long_line", long_line, m_ll);
        chk("R4/R5", "long_field", long_field, m_lf);
        chk("R6", "line_start", line_start, m_ls);
        chk("R6", "frame_start", frame_start, m_fs);
        chk("R7", "pos_lo", pos_lo, (m_v % 256) * 256 + m_h / 2);
        chk("R8", "pos_hi", pos_hi, m_lf * 32768 + m_v / 256);
    endtask

    task automatic pick_inputs();
        cck_en = 1'b1;
        if (phase == 0 && cycles < 3000 && (cycles % 4) == 3) cck_en = 1'b0;
        if (phase == 0 && cycles >= 1000 && cycles < 1020) cck_en = 1'b0;
        if (phase == 1 && m_v < 4 && (cycles % 5) == 2) cck_en = 1'b0;
        mode_60 = (phase != 0);
        lace_en = (phase != 0);
    endtask

    initial begin
        rst_n = 1'b0; cck_en = 1'b1; mode_60 = 1'b0; lace_en = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state with enable high
        chk("R9", "reset hpos", hpos, 0);
        chk("R9", "reset vpos", vpos, 0);
        chk("R9", "reset long_line", long_line, 0);
        chk("R9", "reset long_field", long_field, 1);
        chk("R9", "reset strobes", line_start + frame_start, 0);
        rst_n = 1'b1;
        pick_inputs();
        model_step(cck_en, mode_60, lace_en);
        while (!done) begin
            @(negedge clk);
            cycles++;
            compare_all();
            if (line_start) begin
                if (frame_start) begin
                    // R2 (phase 0), R3 (phase 1), R4 (phase 2): lines per field
                    chk(phase == 0 ? "R2" : (phase == 1 ? "R3" : "R4"), "lines in field", line_cnt, exp_lines);
                    if (phase == 0) chk("R5", "long_field kept with interlace off", long_field, 1);
                    line_cnt = 1;
                end else begin
                    line_cnt++;
                end
            end
            if (m_fs == 1) begin
                phase++;
                exp_lines = (phase == 1) ? 263 : 262;
                if (phase == 3) done = 1;
            end
            if (cycles > 199000) begin
                errors++;
                vectors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                done = 1;
            end
            pick_inputs();
            model_step(cck_en, mode_60, lace_en);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule